// File: doc/BRIEF.md
# Sample Buffer Interrupt and Status Controller

This block sits next to a 1024-entry sample buffer and works out everything software needs to know about that buffer, except the data itself. It watches the buffer's write strobe (one per finished conversion) and its read strobe. From these it keeps the fill level, an empty flag and a sticky overrun flag. It also raises a latched interrupt flag, and that flag drives the interrupt request line.

The event that sets the interrupt flag depends on the conversion mode:
- In software-triggered mode, every accepted sample sets it.
- In paced mode, every 512th accepted sample sets it. 512 is half the buffer.
- In the enhanced residual mode, a 16-bit down-counter counts the samples of the final partial block. Its terminal count sets the flag one last time.

The residual counter is loaded through two byte strobes. Its sequencing is held in a small state machine with four states:
- `RS_IDLE`: the residual gate or the enhanced mode is off.
- `RS_ARMED`: the gate is on, and the block waits for the next half-buffer event.
- `RS_COUNT`: accepted samples count the residual down.
- `RS_DONE`: terminal count has been reached and has raised the interrupt.

The transitions are:
- IDLE→ARMED when both controls are on.
- ARMED→COUNT on a half-buffer event.
- COUNT→DONE on the accepted sample that brings the count to zero.
- Any state→IDLE when either control drops.

Top module: `fifo_irq_ctl`

## Requirements
- R1: After reset the fill level is 0, `fifo_empty` is 1, and `overrun`, `irq_flag`, `irq_req` and `res_count` are all 0.
- R2: A write is accepted when the fill level is below 1024, and it raises the level by one. A read is accepted when the level is nonzero, and it lowers the level by one. `fifo_empty` is 1 exactly when the level is 0. Each of these changes appears one clock after the strobe.
- R3: A write strobe while the level is 1024 sets `overrun`. `overrun` then stays set until `scan_wr`, and reads do not clear it.
- R4: With `trig_src[1]`=0 (software mode), every accepted write sets `irq_flag`. The flag stays set until a `stat_wr` pulse.
- R5: With `trig_src[1]`=1 (paced mode), `irq_flag` is set only by the accepted write that completes each group of 512 accepted writes. The group count starts at zero after reset or after `scan_wr`.
- R6: `irq_req` equals `irq_flag` when `irq_level` is nonzero, and is 0 when `irq_level` is 0.
- R7: A `res_lo_wr` pulse stores `res_byte` as the low byte. A following `res_hi_wr` pulse loads `res_count` with {`res_byte`, stored low byte}.
- R8: With `enh_mode`=1 and `res_gate`=1 (set at least one cycle earlier), the first half-buffer event starts residual counting. Each later accepted write decrements `res_count`. The write that brings it from 1 to 0 sets `irq_flag`, and that happens only once. Further writes neither set the flag nor change the count until the gate is cycled.
- R9: When `stat_wr` and a flag-setting event occur in the same cycle, `irq_flag` ends up set.
- R10: A read while empty leaves the level at 0. A write while the level is 1024 leaves the level at 1024.
- R11: `scan_wr` zeroes the level and clears `overrun`, and it takes priority over a write strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_wr | input | 1 | Sample written into the buffer (one per conversion) |
| smp_rd | input | 1 | Sample read out of the buffer |
| scan_wr | input | 1 | Channel-scan register write; resets the buffer state |
| stat_wr | input | 1 | Status register write; clears the interrupt flag |
| trig_src | input | 2 | Trigger source; bit 1 selects paced (1) or software (0) |
| enh_mode | input | 1 | Enhanced mode: counter serves as residual counter |
| res_gate | input | 1 | Residual gate enable |
| irq_level | input | 4 | Interrupt level selection; 0 disables the request |
| res_lo_wr | input | 1 | Store `res_byte` as the residual low byte |
| res_hi_wr | input | 1 | Load the residual counter with high byte and stored low byte |
| res_byte | input | 8 | Byte data for residual loads |
| fill_count | output | 11 | Current buffer fill level, 0 to 1024 |
| fifo_empty | output | 1 | 1 when the buffer holds no samples |
| overrun | output | 1 | Sticky overrun flag |
| irq_flag | output | 1 | Latched interrupt flag |
| irq_req | output | 1 | Interrupt request line |
| res_count | output | 16 | Residual counter value |

## Verification
The bench drives the residual path through a full sequence. After a 512-sample half-buffer event it counts down five samples, then writes more samples past terminal count. A counter that fired on the wrong sample, fired again, or kept counting below zero would show a flag or a count that differs from the scoreboard. It fills the buffer to exactly 1024 and then writes once more. A design that wrapped the level or cleared overrun on a read would show a level other than 1024 or an overrun of 0 there. It also issues a flag clear together with a new event, and a buffer reset together with a write. These checks catch a design that loses the new interrupt, or one that counts the write which the reset should discard.

// File: rtl/fic_pkg.sv
package fic_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ARMED = 2'd1,
        RS_COUNT = 2'd2,
        RS_DONE  = 2'd3
    } res_state_t;

endpackage

// File: rtl/fic_occupancy.sv
module fic_occupancy #(
    parameter int DEPTH = 1024,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int HALF  = DEPTH / 2,
    parameter int BW    = $clog2(HALF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          overrun,
    output logic          wr_ok,
    output logic          blk_wrap
);

    logic          full;
    logic          rd_ok;
    logic [BW-1:0] blk;
    logic [CW-1:0] count_nxt;

    assign full     = (count == CW'(DEPTH));
    assign wr_ok    = wr && !full && !clr;
    assign rd_ok    = rd && (count != '0) && !clr;
    assign blk_wrap = wr_ok && (blk == BW'(HALF - 1));

    always_comb begin
        if (clr) begin
            count_nxt = '0;
        end else begin
            count_nxt = count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            empty   <= 1'b1;
            overrun <= 1'b0;
            blk     <= '0;
        end else begin
            count <= count_nxt;
            empty <= (count_nxt == '0);
            if (clr) begin
                overrun <= 1'b0;
            end else if (wr && full) begin
                overrun <= 1'b1;
            end
            if (clr || blk_wrap) begin
                blk <= '0;
            end else if (wr_ok) begin
                blk <= blk + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr |=> overrun); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) && !rd && !clr |=> (count == CW'(DEPTH))); // R10
    AST_CLR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty && !overrun); // R11

endmodule

// File: rtl/fic_residual.sv
module fic_residual
    import fic_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          blk_wrap,
    input  logic          wr_ok,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic [7:0]    data,
    output logic [RW-1:0] count,
    output logic          tc
);

    res_state_t state, state_nxt;
    logic [7:0] lo_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (!active) begin
            state_nxt = RS_IDLE;
        end else begin
            unique case (state)
                RS_IDLE:  state_nxt = RS_ARMED;
                RS_ARMED: if (blk_wrap) state_nxt = RS_COUNT;
                RS_COUNT: if (wr_ok && (count <= RW'(1))) state_nxt = RS_DONE;
                RS_DONE:  state_nxt = RS_DONE;
                default:  state_nxt = RS_IDLE;
            endcase
        end
    end

    assign tc = active && (state == RS_COUNT) && wr_ok && (count <= RW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            lo_hold <= '0;
        end else begin
            if (lo_wr) begin
                lo_hold <= data;
            end
            if (hi_wr) begin
                count <= RW'({data, lo_hold});
            end else if (active && (state == RS_COUNT) && wr_ok && (count != '0)) begin
                count <= count - 1'b1;
            end
        end
    end

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DONE) |=> (state == RS_DONE) || (state == RS_IDLE)); // R8
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DONE) && active && !hi_wr |=> $stable(count)); // R8

endmodule

// File: rtl/fifo_irq_ctl.sv
module fifo_irq_ctl #(
    parameter int DEPTH = 1024,
    parameter int RW    = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_wr,
    input  logic          smp_rd,
    input  logic          scan_wr,
    input  logic          stat_wr,
    input  logic [1:0]    trig_src,
    input  logic          enh_mode,
    input  logic          res_gate,
    input  logic [3:0]    irq_level,
    input  logic          res_lo_wr,
    input  logic          res_hi_wr,
    input  logic [7:0]    res_byte,
    output logic [CW-1:0] fill_count,
    output logic          fifo_empty,
    output logic          overrun,
    output logic          irq_flag,
    output logic          irq_req,
    output logic [RW-1:0] res_count
);

    logic wr_ok;
    logic blk_wrap;
    logic res_tc;
    logic event_hit;

    fic_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (smp_wr),
        .rd       (smp_rd),
        .clr      (scan_wr),
        .count    (fill_count),
        .empty    (fifo_empty),
        .overrun  (overrun),
        .wr_ok    (wr_ok),
        .blk_wrap (blk_wrap)
    );

    fic_residual #(.RW(RW)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (enh_mode && res_gate),
        .blk_wrap (blk_wrap),
        .wr_ok    (wr_ok),
        .lo_wr    (res_lo_wr),
        .hi_wr    (res_hi_wr),
        .data     (res_byte),
        .count    (res_count),
        .tc       (res_tc)
    );

    assign event_hit = (trig_src[1] ? blk_wrap : wr_ok) || res_tc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (event_hit) begin
            irq_flag <= 1'b1;
        end else if (stat_wr) begin
            irq_flag <= 1'b0;
        end
    end

    assign irq_req = irq_flag && (irq_level != 4'd0);

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !stat_wr |=> irq_flag); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && smp_wr && !trig_src[1] && !scan_wr && (fill_count < CW'(DEPTH)) |=> irq_flag); // R9
    AST_SW_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_wr && !trig_src[1] && !scan_wr && (fill_count < CW'(DEPTH)) |=> irq_flag); // R4

endmodule

// File: tb/fifo_irq_ctl_bench.sv
`timescale 1ns/100ps
module fifo_irq_ctl_bench;

    localparam int DEPTH = 1024;
    localparam int HALF  = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_wr = 0, smp_rd = 0, scan_wr = 0, stat_wr = 0;
    logic [1:0] trig_src = 2'b00;
    logic enh_mode = 0, res_gate = 0;
    logic [3:0] irq_level = 4'd0;
    logic res_lo_wr = 0, res_hi_wr = 0;
    logic [7:0] res_byte = 8'd0;
    logic [10:0] fill_count;
    logic fifo_empty, overrun, irq_flag, irq_req;
    logic [15:0] res_count;

    always #2 clk = ~clk;

    fifo_irq_ctl u_fifo_irq_ctl (
        .clk(clk), .rst_n(rst_n), .smp_wr(smp_wr), .smp_rd(smp_rd),
        .scan_wr(scan_wr), .stat_wr(stat_wr), .trig_src(trig_src),
        .enh_mode(enh_mode), .res_gate(res_gate), .irq_level(irq_level),
        .res_lo_wr(res_lo_wr), .res_hi_wr(res_hi_wr), .res_byte(res_byte),
        .fill_count(fill_count), .fifo_empty(fifo_empty), .overrun(overrun),
        .irq_flag(irq_flag), .irq_req(irq_req), .res_count(res_count)
    );

    typedef struct {
        string       tag;
        logic [10:0] cnt;
        logic        emp, ovr, flg, req;
        logic [15:0] res;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // mode settings applied by the driver at each step
    logic [1:0] b_ts = 2'b00;
    logic       b_enh = 0, b_gate = 0;
    logic [3:0] b_lvl = 4'd0;

    // reference model state
    int m_cnt = 0, m_blk = 0, m_st = 0;
    bit m_ovr = 0, m_flag = 0;
    logic [15:0] m_res = 16'd0;
    logic [7:0]  m_lo = 8'd0;

    task automatic step(input string tag, input bit wr, input bit rd,
                        input bit clr, input bit sclr, input bit lo,
                        input bit hi, input logic [7:0] b);
        bit full, wok, rok, wrap, act, tc, ev;
        exp_t e;
        @(negedge clk);
        smp_wr = wr; smp_rd = rd; scan_wr = clr; stat_wr = sclr;
        res_lo_wr = lo; res_hi_wr = hi; res_byte = b;
        trig_src = b_ts; enh_mode = b_enh; res_gate = b_gate; irq_level = b_lvl;
        @(posedge clk);
        #1;
        full = (m_cnt == DEPTH);
        wok  = wr && !full && !clr;
        rok  = rd && (m_cnt != 0) && !clr;
        wrap = wok && (m_blk == HALF - 1);
        act  = b_enh && b_gate;
        tc   = act && (m_st == 2) && wok && (m_res <= 16'd1);
        if (hi) m_res = {b, m_lo};
        else if (act && m_st == 2 && wok && m_res != 0) m_res = m_res - 16'd1;
        if (lo) m_lo = b;
        if (!act) m_st = 0;
        else if (m_st == 0) m_st = 1;
        else if (m_st == 1 && wrap) m_st = 2;
        else if (tc) m_st = 3;
        if (clr) m_ovr = 0; else if (wr && full) m_ovr = 1;
        if (clr) m_cnt = 0; else m_cnt = m_cnt + int'(wok) - int'(rok);
        if (clr || wrap) m_blk = 0; else if (wok) m_blk = m_blk + 1;
        ev = (b_ts[1] ? wrap : wok) || tc;
        if (ev) m_flag = 1; else if (sclr) m_flag = 0;
        e.tag = tag; e.cnt = 11'(m_cnt); e.emp = (m_cnt == 0); e.ovr = m_ovr;
        e.flg = m_flag; e.req = m_flag && (b_lvl != 0); e.res = m_res;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 8'd0);
    endtask

    task automatic wr_n(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, 0, 0, 8'd0);
    endtask

    // monitor: pops expected items and compares in mid-cycle
    initial begin
        forever begin
            @(posedge clk);
            #1.5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (fill_count !== e.cnt || fifo_empty !== e.emp || overrun !== e.ovr ||
                    irq_flag !== e.flg || irq_req !== e.req || res_count !== e.res) begin
                    errors++;
                    $display("FAIL %s: got cnt=%0d emp=%0b ovr=%0b flg=%0b req=%0b res=%0d exp cnt=%0d emp=%0b ovr=%0b flg=%0b req=%0b res=%0d",
                             e.tag, fill_count, fifo_empty, overrun, irq_flag, irq_req, res_count,
                             e.cnt, e.emp, e.ovr, e.flg, e.req, e.res);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // software mode, level disabled
        step("R2 first write", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R4 write sets flag", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R6 level zero masks request", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R2 read lowers level", 0, 1, 0, 0, 0, 0, 8'd0);
        step("R4 status write clears flag", 0, 0, 0, 1, 0, 0, 8'd0);
        idle("R4 flag stays clear");
        b_lvl = 4'd5;
        step("R6 request follows flag", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R9 clear and event together", 1, 0, 0, 1, 0, 0, 8'd0);
        step("R11 reset beats write", 1, 0, 1, 0, 0, 0, 8'd0);
        step("R10 read while empty", 0, 1, 0, 1, 0, 0, 8'd0);
        idle("R10 empty stays empty");
        // paced mode: half-buffer events
        b_ts = 2'b10;
        wr_n("R5 no flag before 512", HALF - 1);
        step("R5 flag on 512th", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R5 clear flag", 0, 0, 0, 1, 0, 0, 8'd0);
        wr_n("R2 fill to top", HALF - 1);
        step("R2 level reaches 1024", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R3 write while full", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R10 level held at 1024", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R3 read keeps overrun", 0, 1, 0, 0, 0, 0, 8'd0);
        step("R11 scan write clears", 0, 0, 1, 1, 0, 0, 8'd0);
        // residual loading
        step("R7 low byte", 0, 0, 0, 0, 1, 0, 8'h2C);
        step("R7 high byte", 0, 0, 0, 0, 0, 1, 8'h01);
        step("R7 reload low", 0, 0, 0, 0, 1, 0, 8'h05);
        step("R7 reload high", 0, 0, 0, 0, 0, 1, 8'h00);
        // residual sequence
        b_enh = 1; b_gate = 1;
        idle("R8 arm");
        wr_n("R8 block before last half event", HALF - 1);
        step("R8 last half event", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R8 clear flag", 0, 1, 0, 1, 0, 0, 8'd0);
        wr_n("R8 residual counting", 4);
        step("R8 terminal count", 1, 0, 0, 0, 0, 0, 8'd0);
        step("R8 clear after tc", 0, 0, 0, 1, 0, 0, 8'd0);
        wr_n("R8 no second tc", 3);
        b_gate = 0;
        idle("R8 gate off");
        repeat (4) @(posedge clk);
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule